// File: doc/BRIEF.md
# Keyboard Input Port with Interrupt Request

This block is the device-side interface of a keyboard port. A keyboard source presents an 8-bit character code with a one-cycle strobe. The port latches the code into a data register and marks a character as pending in its status register. It requests service from the processor on a level-held interrupt line, but only while the interrupt enable in its control register is set.

The processor sees three byte-wide registers on a simple synchronous bus: data at offset 0, status at offset 4 and control at offset 8. Reading the data register is the normal way to acknowledge the request. A dedicated acknowledge input clears the request in the same way. Clearing the control register stops the port from interrupting, for example once a full line has been collected. A character that arrives before the previous one was read replaces it and sets a sticky overrun flag.

Top module: `kbd_irq_port`

## Requirements
- R1: A cycle with `key_stb_i` high loads `key_code_i` into the data register, and a later read at offset 0 returns that code. The data register holds its value when no strobe is present.
- R2: A strobe sets the pending flag, status bit 0, in the following cycle.
- R3: `irq_o` is high exactly when the pending flag is set and control bit 1 (write value 0x02) is set. It stays high for as many cycles as the request is left unacknowledged.
- R4: A read at offset 0 clears the pending flag and `irq_o` from the next cycle. A strobe in the same cycle as that read wins, and the flag stays set.
- R5: A cycle with `inta_i` high clears the pending flag in the same way as a data read. A strobe in the same cycle wins.
- R6: Writing 0x00 to control forces `irq_o` low without touching the pending flag. Writing 0x02 again raises `irq_o` while a character is still pending.
- R7: A strobe while a character is pending and not being acknowledged overwrites the data and sets status bit 1 (overrun). The bit stays set until a write to offset 4 with bit 1 set clears it.
- R8: After the active-low reset, data, status and control read 0 and `irq_o` is low.
- R9: `bus_rdata_o` is 0 for reads at unmapped offsets and in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_stb_i | input | 1 | One-cycle strobe: new character present |
| key_code_i | input | 8 | Character code from the keyboard source |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the access cycle |
| inta_i | input | 1 | Explicit interrupt acknowledge |
| irq_o | output | 1 | Level interrupt request to the processor |

## Verification
Assertions check a set of rules on every cycle. The pending flag only rises after a strobe. A data read or an acknowledge without a competing strobe always clears it. The overrun flag never drops without a clear write. The data register never changes without a strobe. Writing zero to control always removes the enable. The ordering cases need the bench's scenarios: a strobe racing a read or an acknowledge, re-enabling while a character is still pending, and an overrun followed by its clear. In those scenarios the reference model follows the exact cycle in which `irq_o` and the status bits change.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  parameter int unsigned OFF_DATA = 0;
  parameter int unsigned OFF_STAT = 4;
  parameter int unsigned OFF_CTRL = 8;
  parameter int unsigned STAT_PEND_BIT = 0;
  parameter int unsigned STAT_OVR_BIT  = 1;
  parameter int unsigned CTRL_IE_BIT   = 1;

  typedef struct packed {
    logic rd_data;
    logic rd_stat;
    logic rd_ctrl;
    logic wr_stat;
    logic wr_ctrl;
  } bus_strb_t;
endpackage

// File: rtl/kbd_bus_dec.sv
module kbd_bus_dec
  import kbd_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output bus_strb_t         strb_o
);
  logic hit_data, hit_stat, hit_ctrl;

  assign hit_data = (addr_i == ADDR_W'(OFF_DATA));
  assign hit_stat = (addr_i == ADDR_W'(OFF_STAT));
  assign hit_ctrl = (addr_i == ADDR_W'(OFF_CTRL));

  always_comb begin
    strb_o.rd_data = sel_i && !we_i && hit_data;
    strb_o.rd_stat = sel_i && !we_i && hit_stat;
    strb_o.rd_ctrl = sel_i && !we_i && hit_ctrl;
    strb_o.wr_stat = sel_i &&  we_i && hit_stat;
    strb_o.wr_ctrl = sel_i &&  we_i && hit_ctrl;
  end
endmodule

// File: rtl/kbd_capture.sv
module kbd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic              ack_i,
  input  logic              ovr_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              pend_o,
  output logic              ovr_o
);
  logic ovr_set;

  // overrun only when the old character is not consumed in the same cycle
  assign ovr_set = stb_i && pend_o && !ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      pend_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (stb_i) data_o <= code_i;
      if (stb_i)      pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
      if (ovr_set)        ovr_o <= 1'b1;
      else if (ovr_clr_i) ovr_o <= 1'b0;
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(data_o)); // R1
  AST_PEND_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(stb_i)); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !stb_i) |=> !pend_o); // R4
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o); // R7
endmodule

// File: rtl/kbd_ctrl_reg.sv
module kbd_ctrl_reg
  import kbd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ie_o <= 1'b0;
    else if (wr_i) ie_o <= wdata_i[CTRL_IE_BIT];
  end

  AST_ZERO_WR_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == '0) |=> !ie_o); // R6
endmodule

// File: rtl/kbd_rd_mux.sv
module kbd_rd_mux
  import kbd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  bus_strb_t         strb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pend_i,
  input  logic              ovr_i,
  input  logic              ie_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] stat_word, ctrl_word;

  always_comb begin
    stat_word = '0;
    stat_word[STAT_PEND_BIT] = pend_i;
    stat_word[STAT_OVR_BIT]  = ovr_i;
    ctrl_word = '0;
    ctrl_word[CTRL_IE_BIT]   = ie_i;
  end

  always_comb begin
    rdata_o = '0;
    if (strb_i.rd_data) rdata_o = data_i;
    if (strb_i.rd_stat) rdata_o = stat_word;
    if (strb_i.rd_ctrl) rdata_o = ctrl_word;
  end

  AST_RD_ONEHOT: assert final ($onehot0({strb_i.rd_data, strb_i.rd_stat, strb_i.rd_ctrl})); // R9
endmodule

// File: rtl/kbd_irq_port.sv
module kbd_irq_port
  import kbd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_stb_i,
  input  logic [DATA_W-1:0] key_code_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              inta_i,
  output logic              irq_o
);
  bus_strb_t         strb;
  logic [DATA_W-1:0] data_q;
  logic              pend_q, ovr_q, ie_q;
  logic              ack, ovr_clr;

  kbd_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i (bus_sel_i),
    .we_i  (bus_we_i),
    .addr_i(bus_addr_i),
    .strb_o(strb)
  );

  // implicit (data read) and explicit acknowledge act alike
  assign ack     = strb.rd_data || inta_i;
  assign ovr_clr = strb.wr_stat && bus_wdata_i[STAT_OVR_BIT];

  kbd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (key_stb_i),
    .code_i   (key_code_i),
    .ack_i    (ack),
    .ovr_clr_i(ovr_clr),
    .data_o   (data_q),
    .pend_o   (pend_q),
    .ovr_o    (ovr_q)
  );

  kbd_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (strb.wr_ctrl),
    .wdata_i(bus_wdata_i),
    .ie_o   (ie_q)
  );

  kbd_rd_mux #(.DATA_W(DATA_W)) u_mux (
    .strb_i (strb),
    .data_i (data_q),
    .pend_i (pend_q),
    .ovr_i  (ovr_q),
    .ie_i   (ie_q),
    .rdata_o(bus_rdata_o)
  );

  assign irq_o = pend_q && ie_q;

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(key_stb_i || strb.wr_ctrl)); // R3
  AST_INTA_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !key_stb_i) |=> !irq_o); // R5
endmodule

// File: tb/tb_kbd_irq_port.sv
module tb_kbd_irq_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       key_stb_i = 1'b0;
  logic [7:0] key_code_i = '0;
  logic       bus_sel_i = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [3:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       inta_i = 1'b0;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_data = 0, m_pend = 0, m_ovr = 0, m_ie = 0;

  always #10 clk_i = ~clk_i;

  kbd_irq_port dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_data <= 0; m_pend <= 0; m_ovr <= 0; m_ie <= 0;
    end else begin
      bit rd0, ack, wst, wct;
      rd0 = bus_sel_i && !bus_we_i && bus_addr_i == 0;
      wst = bus_sel_i &&  bus_we_i && bus_addr_i == 4;
      wct = bus_sel_i &&  bus_we_i && bus_addr_i == 8;
      ack = rd0 || inta_i;
      if (key_stb_i) m_data <= key_code_i;
      if (key_stb_i) m_pend <= 1; else if (ack) m_pend <= 0;
      if (key_stb_i && m_pend == 1 && !ack) m_ovr <= 1;
      else if (wst && bus_wdata_i[1]) m_ovr <= 0;
      if (wct) m_ie <= bus_wdata_i[1];
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk_i) begin
    int exp_rd;
    #1;
    if (rst_ni && !done) begin
      chk("R3 irq", irq_o, m_pend & m_ie);
      exp_rd = 0;
      if (bus_sel_i && !bus_we_i) begin
        if (bus_addr_i == 0) exp_rd = m_data;
        else if (bus_addr_i == 4) exp_rd = m_ovr * 2 + m_pend;
        else if (bus_addr_i == 8) exp_rd = m_ie * 2;
      end
      chk("R9 rdata", bus_rdata_o, exp_rd);
    end
  end

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic key(input logic [7:0] c);
    key_stb_i = 1; key_code_i = c; tick(); key_stb_i = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    tick(); bus_sel_i = 0; bus_we_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    bus_sel_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1 v = bus_rdata_o;
    tick(); bus_sel_i = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) tick();
    rst_ni = 1;
    tick();
    // R8 reset state
    chk("R8 irq", irq_o, 0);
    rd(0, v); chk("R8 data", v, 0);
    rd(4, v); chk("R8 status", v, 0);
    rd(8, v); chk("R8 ctrl", v, 0);

    wr(8, 8'h02);
    rd(8, v); chk("R6 ctrl enable", v, 2);
    key(8'h41);
    rd(4, v); chk("R2 pending", v, 1);
    chk("R3 irq raised", irq_o, 1);
    repeat (3) tick();
    chk("R3 irq held", irq_o, 1);
    rd(0, v); chk("R1 data", v, 8'h41);
    chk("R4 irq cleared by read", irq_o, 0);
    rd(4, v); chk("R4 status cleared", v, 0);

    key(8'h42);
    chk("R5 irq before ack", irq_o, 1);
    inta_i = 1; tick(); inta_i = 0;
    chk("R5 irq after ack", irq_o, 0);
    rd(0, v); chk("R1 data kept", v, 8'h42);

    key(8'h43);
    wr(8, 8'h00);
    chk("R6 irq disabled", irq_o, 0);
    rd(4, v); chk("R6 still pending", v, 1);
    wr(8, 8'h02);
    chk("R6 irq re-raised", irq_o, 1);
    rd(0, v); chk("R1 data 43", v, 8'h43);

    key(8'h44);
    key(8'h45);
    rd(4, v); chk("R7 overrun set", v, 3);
    rd(0, v); chk("R7 overwritten", v, 8'h45);
    rd(4, v); chk("R7 sticky", v, 2);
    wr(4, 8'h02);
    rd(4, v); chk("R7 cleared", v, 0);

    // strobe racing a data read: the new character wins
    bus_sel_i = 1; bus_we_i = 0; bus_addr_i = 0;
    key(8'h46);
    bus_sel_i = 0;
    rd(4, v); chk("R4 strobe wins", v, 1);
    inta_i = 1; key(8'h47); inta_i = 0;
    rd(4, v); chk("R5 strobe wins over ack", v, 1);
    rd(0, v); chk("R1 data 47", v, 8'h47);

    rd(12, v); chk("R9 unmapped", v, 0);
    rd(2, v);  chk("R9 unmapped low", v, 0);

    repeat (2) tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule